// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives frame transmission from a circular list of descriptors kept in shared memory. Software fills descriptors and marks them ready. When the engine is enabled it receives a start pulse and then walks the list. For each descriptor it fetches the 8-byte entry and gathers that descriptor's buffer bytes one at a time through a word-wide memory port. It sends them on a byte stream that has backpressure and an end-of-frame marker. It then writes the descriptor back with its hand-back status fields cleared.

A frame may span several descriptors and ends at the descriptor that carries the end-of-frame flag. The first descriptor of a frame selects the frame options. Short frames can be padded with zero bytes, and a leading 8-byte control block can be stripped from the frame. Each descriptor may request an event pulse. The walk stops at the first descriptor that is not ready. The engine then exposes the address where it stopped and raises a halt flag.

Top module: `txd_ring_walker`

## Requirements
- R1: A descriptor occupies 8 bytes. Bytes 0-1 hold a 16-bit flag word, bytes 2-3 hold a 16-bit byte count, and bytes 4-7 hold a 32-bit buffer address. With `le_i` high, the lower address holds the less significant byte of each field. With `le_i` low, the lower address holds the more significant byte. Memory byte `a+k` travels on lane `k` (bits `8k+7:8k`) of a word at aligned address `a`.
- R2: A `start_i` pulse while `en_i` is high begins a walk at `ptr_i` with its three low bits forced to zero, and clears `halt_o`. While `en_i` is low, `start_i` issues no memory request and leaves `halt_o` unchanged.
- R3: The walk stops at the first descriptor whose flag bit 15 (ready) is clear. It does not write that descriptor. `ptr_o` then holds that descriptor's address and `halt_o` is 1.
- R4: After a descriptor is handled, the next descriptor address is `base_i` with its low three bits zeroed if flag bit 13 (wrap) was set. Otherwise it is the current address plus 8.
- R5: A ready descriptor with a byte count of zero emits no bytes, raises no event, is not written back, and does not begin or end a frame.
- R6: A frame carries the bytes of consecutive descriptors up to and including the one with flag bit 11 (end of frame). `tx_last_o` is high on exactly the final byte of the frame.
- R7: If `pad_en_i` is high or the first descriptor of a frame has flag bit 14 set, a frame that would emit fewer than 64 bytes is extended with zero bytes to exactly 64.
- R8: If the first descriptor of a frame has flag bit 1 set, the first 8 bytes of that frame's gathered data are not emitted.
- R9: A descriptor with flag bit 12 set raises a one-cycle `evt_frame_o` if it ends a frame, or a one-cycle `evt_buf_o` otherwise. Either pulse comes in the cycle after its write-back is accepted.
- R10: Write-back rewrites bytes 0-3 of the descriptor. In the flag word, bits 15, 9, 7, 6, 5:2, 1 and 0 are cleared and the other bits are kept. The byte count is unchanged, and the byte order follows R1.
- R11: At most one memory read is outstanding. A read request is accepted when `mem_req_o && mem_ready_i` with `mem_we_o` low, and its data arrives with a later `mem_rvalid_i`.
- R12: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o` and `tx_last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable |
| start_i | input | 1 | Begin a walk (pulse) |
| le_i | input | 1 | Descriptor byte order: 1 little-endian, 0 big-endian |
| pad_en_i | input | 1 | Pad short frames regardless of descriptor flag |
| base_i | input | AW | Ring base address |
| ptr_i | input | AW | Walk start address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a word write |
| mem_addr_o | output | AW | Word-aligned request address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Stream sink accepts byte |
| evt_frame_o | output | 1 | Frame-done event pulse |
| evt_buf_o | output | 1 | Buffer-done event pulse |
| halt_o | output | 1 | Walk stopped |
| ptr_o | output | AW | Address where the walk stopped |

## Verification
The assertions check the protocol rules on every cycle:
- At most one read is in flight.
- The output byte is held under backpressure.
- The two event pulses are exclusive, and each follows an accepted write.
- Writes are descriptor-aligned.
- Nothing moves while halted.

Only the bench scenarios can show the data-path behaviour:
- descriptor byte order;
- gathering across descriptors, control-block stripping and zero padding to 64 bytes;
- the end-of-frame marker position;
- wrap-around, skipping of empty descriptors, and the exact flag values written back.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned FL_READY   = 15;
  localparam int unsigned FL_PAD     = 14;
  localparam int unsigned FL_WRAP    = 13;
  localparam int unsigned FL_INT     = 12;
  localparam int unsigned FL_LAST    = 11;
  localparam int unsigned FL_OFF     = 1;
  localparam logic [15:0] WB_CLEAR   = 16'h82FF;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_W0, S_RD1, S_W1, S_DEC,
    S_BRD, S_BWT, S_BOUT, S_PAD, S_WB
  } walk_e;
endpackage

// File: rtl/txd_desc_codec.sv
module txd_desc_codec (
  input  logic        le_i,
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  input  logic [15:0] wb_flags_i,
  output logic [15:0] flags_o,
  output logic [15:0] len_o,
  output logic [31:0] bufp_o,
  output logic [31:0] wb_word_o
);
  logic [15:0] len_le, len_be;

  assign len_le = w0_i[31:16];
  assign len_be = {w0_i[23:16], w0_i[31:24]};

  always_comb begin
    if (le_i) begin
      flags_o   = w0_i[15:0];
      len_o     = len_le;
      bufp_o    = w1_i;
      wb_word_o = {len_le, wb_flags_i};
    end else begin
      flags_o   = {w0_i[7:0], w0_i[15:8]};
      len_o     = len_be;
      bufp_o    = {w1_i[7:0], w1_i[15:8], w1_i[23:16], w1_i[31:24]};
      wb_word_o = {len_be[7:0], len_be[15:8], wb_flags_i[7:0], wb_flags_i[15:8]};
    end
  end
endmodule

// File: rtl/txd_frame_ctl.sv
module txd_frame_ctl #(
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned FCB_BYTES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic pad_i,
  input  logic off_i,
  input  logic take_i,
  input  logic emit_i,
  input  logic close_i,
  output logic drop_o,
  output logic short_o,
  output logic near_o,
  output logic pad_on_o,
  output logic in_frame_o
);
  localparam int unsigned RW = $clog2(FCB_BYTES + 1);
  localparam int unsigned EW = $clog2(MIN_FRAME + 1);

  logic [RW-1:0] rd_cnt;
  logic [EW-1:0] em_cnt;
  logic          off_q;

  assign drop_o  = off_q && (rd_cnt < RW'(FCB_BYTES));
  assign short_o = em_cnt < EW'(MIN_FRAME);
  assign near_o  = em_cnt == EW'(MIN_FRAME - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt     <= '0;
      em_cnt     <= '0;
      off_q      <= 1'b0;
      pad_on_o   <= 1'b0;
      in_frame_o <= 1'b0;
    end else if (open_i) begin
      rd_cnt     <= '0;
      em_cnt     <= '0;
      off_q      <= off_i;
      pad_on_o   <= pad_i;
      in_frame_o <= 1'b1;
    end else if (close_i) begin
      rd_cnt     <= '0;
      em_cnt     <= '0;
      in_frame_o <= 1'b0;
    end else begin
      if (take_i && drop_o) rd_cnt <= rd_cnt + 1'b1;
      if (emit_i && short_o) em_cnt <= em_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker #(
  parameter int unsigned AW        = 32,
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned FCB_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          le_i,
  input  logic          pad_en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ptr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          evt_frame_o,
  output logic          evt_buf_o,
  output logic          halt_o,
  output logic [AW-1:0] ptr_o
);
  import txd_pkg::*;

  localparam logic [AW-1:0] DESC_MASK = ~AW'(DESC_BYTES - 1);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

  walk_e         state;
  logic [AW-1:0] cur;
  logic [31:0]   w0, w1;
  logic [15:0]   byte_idx;
  logic [7:0]    byte_q;

  logic [15:0]   flags, len;
  logic [31:0]   bufp, wb_word;
  logic [AW-1:0] baddr, next_addr;
  logic          byte_fin, desc_last, need_pad, advance;
  logic          open, take, emit, close;
  logic          drop, short_f, near_f, pad_on, in_frame;

  txd_desc_codec u_codec (
    .le_i      (le_i),
    .w0_i      (w0),
    .w1_i      (w1),
    .wb_flags_i(flags & ~WB_CLEAR),
    .flags_o   (flags),
    .len_o     (len),
    .bufp_o    (bufp),
    .wb_word_o (wb_word)
  );

  txd_frame_ctl #(.MIN_FRAME(MIN_FRAME), .FCB_BYTES(FCB_BYTES)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open),
    .pad_i     (flags[FL_PAD] | pad_en_i),
    .off_i     (flags[FL_OFF]),
    .take_i    (take),
    .emit_i    (emit),
    .close_i   (close),
    .drop_o    (drop),
    .short_o   (short_f),
    .near_o    (near_f),
    .pad_on_o  (pad_on),
    .in_frame_o(in_frame)
  );

  assign baddr     = AW'(bufp) + AW'(byte_idx);
  assign next_addr = flags[FL_WRAP] ? (base_i & DESC_MASK) : cur + AW'(DESC_BYTES);
  assign byte_fin  = byte_idx == len - 16'd1;
  assign desc_last = flags[FL_LAST];
  // pad needed once this byte is out: emitted count after it still below minimum
  assign need_pad  = pad_on && (drop ? short_f : (short_f && !near_f));
  assign advance   = drop || tx_ready_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur;
    mem_wdata_o = wb_word;
    tx_valid_o  = 1'b0;
    tx_data_o   = byte_q;
    tx_last_o   = 1'b0;
    open        = 1'b0;
    take        = 1'b0;
    emit        = 1'b0;
    close       = 1'b0;
    unique case (state)
      S_RD0: mem_req_o = 1'b1;
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur + AW'(4);
      end
      S_DEC: open = flags[FL_READY] && (len != 16'd0) && !in_frame;
      S_BRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = baddr & WORD_MASK;
      end
      S_BOUT: begin
        tx_valid_o = !drop;
        tx_last_o  = byte_fin && desc_last && !need_pad;
        take       = advance;
        emit       = advance && !drop;
      end
      S_PAD: begin
        tx_valid_o = 1'b1;
        tx_data_o  = 8'h00;
        tx_last_o  = near_f;
        emit       = tx_ready_i;
      end
      S_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        close     = mem_ready_i && desc_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= S_IDLE;
      cur         <= '0;
      w0          <= '0;
      w1          <= '0;
      byte_idx    <= '0;
      byte_q      <= '0;
      halt_o      <= 1'b0;
      ptr_o       <= '0;
      evt_frame_o <= 1'b0;
      evt_buf_o   <= 1'b0;
    end else begin
      evt_frame_o <= 1'b0;
      evt_buf_o   <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i && en_i) begin
          cur    <= ptr_i & DESC_MASK;
          halt_o <= 1'b0;
          state  <= S_RD0;
        end
        S_RD0: if (mem_ready_i) state <= S_W0;
        S_W0: if (mem_rvalid_i) begin
          w0    <= mem_rdata_i;
          state <= S_RD1;
        end
        S_RD1: if (mem_ready_i) state <= S_W1;
        S_W1: if (mem_rvalid_i) begin
          w1    <= mem_rdata_i;
          state <= S_DEC;
        end
        S_DEC: begin
          if (!flags[FL_READY]) begin
            ptr_o  <= cur;
            halt_o <= 1'b1;
            state  <= S_IDLE;
          end else if (len == 16'd0) begin
            cur   <= next_addr;
            state <= S_RD0;
          end else begin
            byte_idx <= '0;
            state    <= S_BRD;
          end
        end
        S_BRD: if (mem_ready_i) state <= S_BWT;
        S_BWT: if (mem_rvalid_i) begin
          byte_q <= mem_rdata_i[{baddr[1:0], 3'b000} +: 8];
          state  <= S_BOUT;
        end
        S_BOUT: if (advance) begin
          byte_idx <= byte_idx + 16'd1;
          if (!byte_fin)                  state <= S_BRD;
          else if (desc_last && need_pad) state <= S_PAD;
          else                            state <= S_WB;
        end
        S_PAD: if (tx_ready_i && near_f) state <= S_WB;
        S_WB: if (mem_ready_i) begin
          evt_frame_o <= flags[FL_INT] && desc_last;
          evt_buf_o   <= flags[FL_INT] && !desc_last;
          cur         <= next_addr;
          state       <= S_RD0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          mem_rvalid_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic          tx_ready_i,
  input logic          evt_frame_o,
  input logic          evt_buf_o,
  input logic          halt_o
);
  logic pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       pend <= 1'b0;
    else if (mem_rvalid_i)                             pend <= 1'b0;
    else if (mem_req_o && !mem_we_o && mem_ready_i)    pend <= 1'b1;
  end

  p_one_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> !(mem_req_o && !mem_we_o));

  p_tx_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  p_evt_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_frame_o && evt_buf_o));

  p_evt_after_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_frame_o || evt_buf_o) |-> $past(mem_req_o && mem_we_o && mem_ready_i));

  p_wb_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[2:0] == 3'b000));

  p_halt_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!mem_req_o && !tx_valid_o));
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .mem_rvalid_i(mem_rvalid_i),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_last_o   (tx_last_o),
  .tx_ready_i  (tx_ready_i),
  .evt_frame_o (evt_frame_o),
  .evt_buf_o   (evt_buf_o),
  .halt_o      (halt_o)
);

// File: tb/txd_ring_walker_test.sv
module txd_ring_walker_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, en, start, le, pad_en;
  logic [31:0] base, ptr;
  logic        mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready, evt_frame, evt_buf, halt;
  logic [7:0]  tx_data;
  logic [31:0] ptr_out;

  txd_ring_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .le_i(le),
    .pad_en_i(pad_en), .base_i(base), .ptr_i(ptr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .evt_frame_o(evt_frame),
    .evt_buf_o(evt_buf), .halt_o(halt), .ptr_o(ptr_out)
  );

  logic [7:0] mem [0:1023];
  logic [7:0] cap_data [0:255];
  logic       cap_last [0:255];
  int cap_n, n_frame, n_buf, n_req, cyc;
  int n_tests = 0, n_fail = 0;

  // memory model: one-cycle read latency, stalls on a fixed pattern
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++) mem[mem_addr[9:0] + 10'(k)] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                       mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
      end
    end
    if (rst_n && mem_req) n_req <= n_req + 1;
    if (rst_n && tx_valid && tx_ready) begin
      cap_data[cap_n[7:0]] <= tx_data;
      cap_last[cap_n[7:0]] <= tx_last;
      cap_n <= cap_n + 1;
    end
    if (evt_frame) n_frame <= n_frame + 1;
    if (evt_buf)   n_buf <= n_buf + 1;
    mem_ready <= (cyc % 5) != 3;
    tx_ready  <= (cyc % 7) != 2;
    cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln,
                          input logic [31:0] p, input bit lo_first);
    if (lo_first) begin
      mem[a] = fl[7:0];  mem[a+1] = fl[15:8];
      mem[a+2] = ln[7:0]; mem[a+3] = ln[15:8];
      mem[a+4] = p[7:0]; mem[a+5] = p[15:8]; mem[a+6] = p[23:16]; mem[a+7] = p[31:24];
    end else begin
      mem[a] = fl[15:8]; mem[a+1] = fl[7:0];
      mem[a+2] = ln[15:8]; mem[a+3] = ln[7:0];
      mem[a+4] = p[31:24]; mem[a+5] = p[23:16]; mem[a+6] = p[15:8]; mem[a+7] = p[7:0];
    end
  endtask

  function automatic logic [15:0] get16(input int a, input bit lo_first);
    return lo_first ? {mem[a+1], mem[a]} : {mem[a], mem[a+1]};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    cap_n = 0; n_frame = 0; n_buf = 0; n_req = 0;
  endtask

  task automatic run_walk(input int p);
    @(negedge clk); ptr = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      if (halt) break;
      @(negedge clk);
    end
    check(halt == 1'b1, "R3 walk halts", halt, 1);
    repeat (3) @(negedge clk);
  endtask

  // {total bytes, bytes in first descriptor (0 = one descriptor), opts}
  // opts: bit0 descriptor pad, bit1 strip, bit2 little-endian, bit3 event, bit4 global pad
  localparam logic [23:0] VEC [6] = '{
    {8'd70,  8'd0,  8'h00},
    {8'd20,  8'd0,  8'h05},
    {8'd100, 8'd30, 8'h0E},
    {8'd30,  8'd10, 8'h1A},
    {8'd64,  8'd0,  8'h01},
    {8'd12,  8'd0,  8'h03}
  };

  logic [7:0] exp_b [0:255];

  initial begin
    rst_n = 1'b0; en = 1'b0; start = 1'b0; le = 1'b0; pad_en = 1'b0;
    base = 32'h100; ptr = 32'h0; cyc = 0;
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(halt == 1'b0 && tx_valid == 1'b0 && mem_req == 1'b0, "R3 reset idle",
          {halt, tx_valid, mem_req}, 0);
    check(evt_frame == 1'b0 && evt_buf == 1'b0, "R9 reset no event", {evt_frame, evt_buf}, 0);

    // disabled: start ignored
    put_desc(32'h100, 16'h8800, 16'd4, 32'h200, 1'b0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    check(n_req == 0, "R2 start ignored while disabled", n_req, 0);
    check(halt == 1'b0, "R2 halt unchanged while disabled", halt, 0);
    en = 1'b1;

    foreach (VEC[v]) begin
      int tot, n1, nd, en_cnt, mism, lasts;
      bit pd, off, lo, intr;
      logic [15:0] f0, f1;
      tot = int'(VEC[v][23:16]); n1 = int'(VEC[v][15:8]);
      pd = VEC[v][0] | VEC[v][4]; off = VEC[v][1]; lo = VEC[v][2]; intr = VEC[v][3];
      nd = (n1 == 0) ? 1 : 2;
      if (n1 == 0) n1 = tot;
      clear_all();
      le = lo; pad_en = VEC[v][4];
      f0 = 16'h8000 | 16'h0400 | 16'h02FD | ((nd == 1) ? 16'h0800 : 16'h0)
         | (16'(VEC[v][0]) << 14) | (16'(intr) << 12) | (16'(off) << 1);
      put_desc(32'h100, f0, 16'(n1), 32'h201, lo);
      for (int i = 0; i < n1; i++) mem[32'h201 + i] = 8'(i * 7 + v * 13 + 1);
      f1 = 16'h8800 | (16'(intr) << 12);
      if (nd == 2) begin
        put_desc(32'h108, f1, 16'(tot - n1), 32'h2C3, lo);
        for (int i = n1; i < tot; i++) mem[32'h2C3 + i - n1] = 8'(i * 7 + v * 13 + 1);
      end
      en_cnt = 0;
      for (int i = 0; i < tot; i++)
        if (!(off && i < 8)) begin exp_b[en_cnt] = 8'(i * 7 + v * 13 + 1); en_cnt++; end
      if (pd) while (en_cnt < 64) begin exp_b[en_cnt] = 8'h00; en_cnt++; end

      run_walk(32'h103);

      check(cap_n == en_cnt, "R7 R8 emitted byte count", cap_n, en_cnt);
      mism = 0; lasts = 0;
      for (int i = 0; i < cap_n && i < 256; i++) begin
        if (cap_data[i] != exp_b[i]) mism++;
        if (cap_last[i]) lasts++;
      end
      check(mism == 0, "R1 R6 stream bytes", mism, 0);
      check(lasts == 1 && cap_n > 0 && cap_last[cap_n - 1], "R6 single final marker", lasts, 1);
      check(ptr_out == 32'h100 + 32'(8 * nd), "R2 R3 R4 stop pointer", ptr_out, 32'h100 + 8 * nd);
      check(get16(32'h100, lo) == (f0 & ~16'h82FF), "R10 flags written back",
            get16(32'h100, lo), f0 & ~16'h82FF);
      check(get16(32'h102, lo) == 16'(n1), "R10 length kept", get16(32'h102, lo), n1);
      if (nd == 2)
        check(get16(32'h108, lo) == (f1 & ~16'h82FF), "R10 second flags written back",
              get16(32'h108, lo), f1 & ~16'h82FF);
      check(n_frame == int'(intr), "R9 frame events", n_frame, int'(intr));
      check(n_buf == ((intr && nd == 2) ? 1 : 0), "R9 buffer events", n_buf, int'(intr && nd == 2));
    end

    // directed: empty descriptor, wrap back to base
    clear_all();
    le = 1'b0; pad_en = 1'b0;
    put_desc(32'h110, 16'h8000, 16'd0, 32'h200, 1'b0);
    put_desc(32'h118, 16'hA800, 16'd4, 32'h240, 1'b0);
    for (int i = 0; i < 4; i++) mem[32'h240 + i] = 8'(8'hA0 + i);
    run_walk(32'h110);
    check(cap_n == 4, "R5 empty descriptor emits nothing", cap_n, 4);
    check(cap_data[0] == 8'hA0 && cap_data[3] == 8'hA3 && cap_last[3], "R6 small frame",
          cap_data[3], 8'hA3);
    check(get16(32'h110, 1'b0) == 16'h8000, "R5 empty descriptor not written",
          get16(32'h110, 1'b0), 16'h8000);
    check(ptr_out == 32'h100, "R4 wrap to base", ptr_out, 32'h100);
    check(get16(32'h118, 1'b0) == 16'h2800, "R10 wrap descriptor write-back",
          get16(32'h118, 1'b0), 16'h2800);
    check(n_frame == 0 && n_buf == 0, "R9 no event without request", n_frame + n_buf, 0);

    // directed: halted ring restarts after disable drops start
    en = 1'b0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check(halt == 1'b1, "R2 halt held while disabled", halt, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R3 actual=hung expected=halt");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule